// File: doc/BRIEF.md
# Banked GPIO Controller with Grouped Edge Interrupts

The controller gives software control of a parameterised number of 32-pin banks through a register bus on which every access completes in one cycle. Each pin has a direction bit. Its output level is changed by writing a whole word, or by writing ones to a set register or a clear register. Its input level can always be read back, after a two-stage synchroniser.

Edge detection works on the synchronised input. Rising and falling edges are enabled separately for each pin, each kind through its own pair of write-one-to-set and write-one-to-clear registers. A detected edge sets a sticky status bit, which software clears by writing a one to it.

Each 16-pin half of a bank forms an interrupt group. A group's interrupt line is raised when any status bit in the group is set and the group's bit in a shared enable register is on.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset:
  - every pin is an input (`pin_oe_o` all zero, direction reads all ones);
  - `pin_o` is zero;
  - all edge enables, status bits and group enables are zero;
  - `irq_o` is zero.
- R2: The direction register is at bank offset 0x00. Bit value 1 makes the pin an input and 0 makes it an output. `pin_oe_o` is the bitwise inverse of the register, and the register reads back as written.
- R3: Writing ones to the set-data register (offset 0x08) drives those pins high. Writing ones to the clear-data register (offset 0x0C) drives them low. Zero bits leave a pin unchanged. Both registers read back the current output word.
- R4: The output-data register at offset 0x04 is written as a whole word, drives `pin_o` directly in the next cycle, and reads back.
- R5: The input-data register at offset 0x10 returns the level on `pin_i` after two clock stages, whatever the pin's direction. A read issued in the same cycle that a pin changes returns the old level.
- R6: The rising-edge enable is set at offset 0x14 and cleared at offset 0x18. The falling-edge enable is set at offset 0x1C and cleared at offset 0x20. Each pair reads back the current enable word.
- R7: The status register at offset 0x24 latches every enabled edge of the synchronised input. An edge whose enable is off sets nothing, and a set status bit stays set until it is cleared.
- R8: Writing a 1 to a status bit clears it, and a 0 leaves it unchanged. If an enabled edge arrives in the same cycle as the clearing write, the bit stays set.
- R9: The group-enable register is at address 0x08. Bit g gates group g, where g = 2*bank + half and half 1 covers pins 16..31 of the bank. `irq_o[g]` is the OR of the group's status bits ANDed with that enable bit.
- R10: Bank b occupies addresses 0x10 + 0x28*b up to 0x37 + 0x28*b. A read of any address not mapped returns zero, and a write to one changes no state.
- R11: Read data appears on `bus_rdata_o` in the cycle after the read request and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W (8) | Byte address |
| bus_wdata_i | input | BANK_W (32) | Write data |
| bus_rdata_o | output | BANK_W (32) | Read data, registered |
| pin_i | input | NUM_BANKS*BANK_W (64) | Pin levels from the pads |
| pin_o | output | NUM_BANKS*BANK_W (64) | Output levels to the pads |
| pin_oe_o | output | NUM_BANKS*BANK_W (64) | Output enables, 1 = drive |
| irq_o | output | NUM_BANKS*2 (4) | Group interrupt lines |

## Verification
The output path is tried in three ways: mixed set and clear masks, a whole-word write, and an all-zero mask. Together these separate write-one semantics from plain overwrite and from a missing zero-bit guard.

Input readback is sampled twice: in the same cycle a pin changes, and after the synchroniser has settled. This exposes a missing or extra stage.

Edges are applied in four forms:
- rising edges on enabled pins;
- a rising edge on a disabled pin;
- a falling edge on a pin with only rising enabled;
- a falling edge timed to meet a clearing write.

These separate enable gating, edge polarity and the priority of set over clear. Group enables are toggled one at a time, so that a swapped group index shows up. Reads of unmapped addresses and a write to one catch decode that aliases onto a bank.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  // bank-relative register offsets
  localparam logic [5:0] OFF_DIR      = 6'h00;
  localparam logic [5:0] OFF_OUT      = 6'h04;
  localparam logic [5:0] OFF_OUT_SET  = 6'h08;
  localparam logic [5:0] OFF_OUT_CLR  = 6'h0C;
  localparam logic [5:0] OFF_IN       = 6'h10;
  localparam logic [5:0] OFF_RISE_SET = 6'h14;
  localparam logic [5:0] OFF_RISE_CLR = 6'h18;
  localparam logic [5:0] OFF_FALL_SET = 6'h1C;
  localparam logic [5:0] OFF_FALL_CLR = 6'h20;
  localparam logic [5:0] OFF_STAT     = 6'h24;

  localparam int unsigned BANK_BASE   = 'h10;
  localparam int unsigned BANK_STRIDE = 'h28;
  localparam int unsigned GRP_EN_ADDR = 'h08;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[s] <= '0;
      end else begin
        if (s == 0) begin
          stage_q[s] <= d_i;
        end else begin
          stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_edge_pkg::*;
#(
  parameter int unsigned BANK_W     = 32,
  parameter int unsigned GRP_W      = 16,
  parameter int unsigned SYNC_DEPTH = 2,
  localparam int unsigned GRPS      = BANK_W / GRP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [5:0]        off_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] rdata_o,
  input  logic [BANK_W-1:0] pin_i,
  output logic [BANK_W-1:0] pin_o,
  output logic [BANK_W-1:0] pin_oe_o,
  output logic [GRPS-1:0]   grp_pend_o
);
  logic [BANK_W-1:0] dir_q, out_q, rise_en_q, fall_en_q, stat_q, stat_d;
  logic [BANK_W-1:0] in_sync, in_prev_q, edge_hit, stat_clr;

  gpio_sync #(.W(BANK_W), .STAGES(SYNC_DEPTH)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (in_sync)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_prev_q <= '0;
    else         in_prev_q <= in_sync;
  end

  assign edge_hit = (in_sync & ~in_prev_q & rise_en_q) |
                    (~in_sync & in_prev_q & fall_en_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q     <= '1;
      out_q     <= '0;
      rise_en_q <= '0;
      fall_en_q <= '0;
    end else if (wr_i) begin
      case (off_i)
        OFF_DIR:      dir_q     <= wdata_i;
        OFF_OUT:      out_q     <= wdata_i;
        OFF_OUT_SET:  out_q     <= out_q | wdata_i;
        OFF_OUT_CLR:  out_q     <= out_q & ~wdata_i;
        OFF_RISE_SET: rise_en_q <= rise_en_q | wdata_i;
        OFF_RISE_CLR: rise_en_q <= rise_en_q & ~wdata_i;
        OFF_FALL_SET: fall_en_q <= fall_en_q | wdata_i;
        OFF_FALL_CLR: fall_en_q <= fall_en_q & ~wdata_i;
        default: ;
      endcase
    end
  end

  // new edges win over a simultaneous clear
  assign stat_clr = (wr_i && off_i == OFF_STAT) ? wdata_i : '0;
  assign stat_d   = (stat_q & ~stat_clr) | edge_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  always_comb begin
    case (off_i)
      OFF_DIR:                   rdata_o = dir_q;
      OFF_OUT, OFF_OUT_SET,
      OFF_OUT_CLR:               rdata_o = out_q;
      OFF_IN:                    rdata_o = in_sync;
      OFF_RISE_SET, OFF_RISE_CLR: rdata_o = rise_en_q;
      OFF_FALL_SET, OFF_FALL_CLR: rdata_o = fall_en_q;
      OFF_STAT:                  rdata_o = stat_q;
      default:                   rdata_o = '0;
    endcase
  end

  for (genvar g = 0; g < GRPS; g++) begin : g_grp
    assign grp_pend_o[g] = |stat_q[g*GRP_W +: GRP_W];
  end

  assign pin_o    = out_q;
  assign pin_oe_o = ~dir_q;

  p_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && off_i == OFF_OUT_SET) |=> ((pin_o & $past(wdata_i)) == $past(wdata_i)));

  p_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && off_i == OFF_OUT_CLR) |=> ((pin_o & $past(wdata_i)) == '0));

  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && off_i == OFF_STAT) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  p_w1c_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && off_i == OFF_STAT && edge_hit == '0) |=> ((stat_q & $past(wdata_i)) == '0));

  p_edge_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_hit != '0) |=> ((stat_q & $past(edge_hit)) == $past(edge_hit)));
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned GRP_W     = 16,
  localparam int unsigned GPB      = BANK_W / GRP_W,
  localparam int unsigned NUM_PINS = NUM_BANKS * BANK_W,
  localparam int unsigned NUM_GRPS = NUM_BANKS * GPB
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_req_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [BANK_W-1:0]   bus_wdata_i,
  output logic [BANK_W-1:0]   bus_rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic [NUM_GRPS-1:0] irq_o
);
  logic [NUM_BANKS-1:0] bank_hit;
  logic [BANK_W-1:0]    bank_rd [NUM_BANKS];
  logic [NUM_GRPS-1:0]  pend_all, grp_en_q;
  logic [BANK_W-1:0]    rdata_d, rdata_q;
  logic                 ge_hit, rd_req;

  assign ge_hit = (bus_addr_i == ADDR_W'(GRP_EN_ADDR));
  assign rd_req = bus_req_i && !bus_we_i;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BANK_BASE + b * BANK_STRIDE);
    logic [ADDR_W-1:0] loc;
    logic [GPB-1:0]    pend;

    assign loc         = bus_addr_i - BASE;
    assign bank_hit[b] = (bus_addr_i >= BASE) && (loc < ADDR_W'(BANK_STRIDE));

    gpio_bank #(.BANK_W(BANK_W), .GRP_W(GRP_W)) i_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (bus_req_i && bus_we_i && bank_hit[b]),
      .off_i     (loc[5:0]),
      .wdata_i   (bus_wdata_i),
      .rdata_o   (bank_rd[b]),
      .pin_i     (pin_i[b*BANK_W +: BANK_W]),
      .pin_o     (pin_o[b*BANK_W +: BANK_W]),
      .pin_oe_o  (pin_oe_o[b*BANK_W +: BANK_W]),
      .grp_pend_o(pend)
    );

    assign pend_all[b*GPB +: GPB] = pend;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           grp_en_q <= '0;
    else if (bus_req_i && bus_we_i && ge_hit) grp_en_q <= bus_wdata_i[NUM_GRPS-1:0];
  end

  always_comb begin
    rdata_d = ge_hit ? BANK_W'(grp_en_q) : '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b]) rdata_d = rdata_d | bank_rd[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_req) rdata_q <= rdata_d;
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = pend_all & grp_en_q;

  p_rd_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> $stable(bus_rdata_o));

  p_unmapped_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && !ge_hit && bank_hit == '0) |=> (bus_rdata_o == '0));

  p_onehot_hit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ge_hit, bank_hit}));
endmodule

// File: tb/test_gpio_edge_ctrl.sv
module test_gpio_edge_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] pin_in = '0;
  logic [63:0] pin_out, pin_oe;
  logic [3:0]  irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  typedef struct { logic [31:0] exp; string tag; } sb_item_t;
  sb_item_t sb_q[$];
  logic rd_pend = 1'b0;

  always #4 clk = ~clk;

  gpio_edge_ctrl i_gpio_edge_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // driver: queue the expectation, then issue the read
  task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
    sb_q.push_back('{exp: e, tag: tag});
    req = 1; we = 0; addr = a;
    @(negedge clk);
    req = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  always @(posedge clk) rd_pend <= req && !we;

  // monitor: compare read data in the cycle after the request (R11)
  always @(negedge clk) begin
    if (rd_pend) begin
      if (sb_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R11: unexpected read data %h expected none", rdata);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        chk(it.tag, {32'h0, rdata}, {32'h0, it.exp});
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 oe", pin_oe, 64'h0);
    chk("R1 out", pin_out, 64'h0);
    chk("R1 irq", {60'h0, irq}, 64'h0);
    rd(8'h10, 32'hFFFF_FFFF, "R1 dir bank0");
    rd(8'h34, 32'h0, "R1 status bank0");
    rd(8'h4C, 32'h0, "R1 rise enable bank1");
    rd(8'h08, 32'h0, "R1 group enable");

    // R2 direction
    wr(8'h10, 32'hFFFF_0000);
    chk("R2 oe", pin_oe, 64'h0000_0000_0000_FFFF);
    rd(8'h10, 32'hFFFF_0000, "R2 dir readback");

    // R3 set / clear
    wr(8'h18, 32'h0000_00F0);
    chk("R3 set", pin_out, 64'h0000_0000_0000_00F0);
    wr(8'h1C, 32'h0000_0030);
    chk("R3 clear", pin_out, 64'h0000_0000_0000_00C0);
    wr(8'h18, 32'h0);
    chk("R3 zero mask", pin_out, 64'h0000_0000_0000_00C0);
    rd(8'h18, 32'h0000_00C0, "R3 set readback");
    rd(8'h1C, 32'h0000_00C0, "R3 clear readback");

    // R4 whole-word output
    wr(8'h14, 32'h1234_5678);
    chk("R4 out word", pin_out, 64'h0000_0000_1234_5678);
    rd(8'h14, 32'h1234_5678, "R4 out readback");

    // R5 synchronised input, readable on output pins too
    pin_in[31:0] = 32'hA5A5_0001;
    rd(8'h20, 32'h0, "R5 old level");
    repeat (3) @(negedge clk);
    rd(8'h20, 32'hA5A5_0001, "R5 new level");

    // R6 edge enables on bank1
    wr(8'h4C, 32'h0001_0001);
    wr(8'h54, 32'h0000_0001);
    rd(8'h4C, 32'h0001_0001, "R6 rise set readback");
    rd(8'h50, 32'h0001_0001, "R6 rise clr readback");
    rd(8'h54, 32'h0000_0001, "R6 fall readback");

    // R7 latching of enabled edges only
    pin_in[32] = 1'b1;
    repeat (4) @(negedge clk);
    rd(8'h5C, 32'h0000_0001, "R7 rise latched");
    pin_in[33] = 1'b1;
    repeat (4) @(negedge clk);
    rd(8'h5C, 32'h0000_0001, "R7 disabled edge ignored");
    pin_in[48] = 1'b1;
    repeat (4) @(negedge clk);
    rd(8'h5C, 32'h0001_0001, "R7 second rise latched");
    chk("R9 gated off", {60'h0, irq}, 64'h0);

    // R9 group gating
    wr(8'h08, 32'h4);
    chk("R9 group2", {60'h0, irq}, 64'h4);
    wr(8'h08, 32'hC);
    chk("R9 group2+3", {60'h0, irq}, 64'hC);
    rd(8'h08, 32'hC, "R9 enable readback");

    // R8 write-one-to-clear
    wr(8'h5C, 32'h0001_0000);
    chk("R8 clear group3", {60'h0, irq}, 64'h4);
    rd(8'h5C, 32'h0000_0001, "R8 cleared bit");
    wr(8'h5C, 32'h0);
    rd(8'h5C, 32'h0000_0001, "R8 zero write");

    // R7 falling edge on rise-only pin ignored
    pin_in[48] = 1'b0;
    repeat (4) @(negedge clk);
    rd(8'h5C, 32'h0000_0001, "R7 wrong polarity ignored");

    // R8 edge arriving with the clearing write wins
    pin_in[32] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    wr(8'h5C, 32'h0000_0001);
    rd(8'h5C, 32'h0000_0001, "R8 edge beats clear");
    wr(8'h5C, 32'h0000_0001);
    rd(8'h5C, 32'h0, "R8 final clear");
    chk("R9 all quiet", {60'h0, irq}, 64'h0);

    wr(8'h58, 32'h0000_0001);
    rd(8'h54, 32'h0, "R6 fall cleared");

    // R10 decode
    rd(8'h00, 32'h0, "R10 addr 0x00");
    rd(8'h0C, 32'h0, "R10 addr 0x0C");
    rd(8'h60, 32'h0, "R10 past last bank");
    wr(8'h60, 32'hFFFF_FFFF);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h38, 32'hFFFF_FFFF, "R10 bank1 dir untouched");
    rd(8'h5C, 32'h0, "R10 bank1 status untouched");
    rd(8'h08, 32'hC, "R10 group enable untouched");
    chk("R10 outputs untouched", pin_out, 64'h0000_0000_1234_5678);

    // R11 read data held without a read
    repeat (3) @(negedge clk);
    chk("R11 hold", {32'h0, rdata}, 64'hC);

    repeat (2) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R11: got %0d pending reads expected 0", sb_q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule